// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings one power-gated domain down or back up when software asks for it. Software writes a control register that holds two request bits, one per direction. Two timing registers give the waits for each direction. A gating-enable register decides whether a power-down request may proceed. The block then drives the power-switch enable and isolation outputs in a safe order. Isolation always covers the domain while its supply is off.

Every wait is a number of count-clock periods. The count clock is the bus clock divided by a slow or a fast ratio, and a mode bit in the power-up timing register selects which ratio applies. The request bit of the running sequence reads 1 until the last step is done. Hardware then clears it, so software polls the control register to see when the sequence is complete.

Top module: `pwr_switch_seq`

## Requirements
- R1: After reset, pwr_sw_en is 1, pwr_iso_en is 0, and all four registers read 0.
- R2: Registers are at word addresses 0 (control: bit 0 requests power-down, bit 1 requests power-up), 1 (gating enable, bit 0), 2 (power-up timing) and 3 (power-down timing). Each timing register holds a first count in bits [5:0] and a second count in bits [13:8]. Unimplemented bits read 0.
- R3: Power-down starts on a control write with bit 0 set, while idle and with gating enable bit 0 set to 1. pwr_iso_en rises on the write edge. pwr_sw_en falls max(F*D,1) cycles later, where F is the power-down first count and D is the active divide ratio. The request clears a further max(S*D,1) cycles later, where S is the power-down second count.
- R4: Power-up starts on a control write with bit 1 set and bit 0 clear, while idle. pwr_sw_en rises on the write edge. pwr_iso_en falls, and the request clears, max(F*D,1)+max(S*D,1) cycles after the write, using the power-up counts.
- R5: A power-down request written while gating enable bit 0 is 0 has no effect: the outputs stay as they were and the control register reads 0.
- R6: A control write with both bits set starts only a power-down. If gating is disabled, that write starts nothing.
- R7: Control writes made while a sequence runs are ignored, and no new sequence follows when the running one completes.
- R8: Bit 5 of the power-up timing register, sampled when a sequence starts, selects D = DIV_FAST when 1 and D = DIV_SLOW when 0, for both directions.
- R9: The request bit of the running direction reads 1 for the whole sequence and 0 once it completes. At most one request bit is 1 at any time.
- R10: The power switch opens only while isolation is asserted, and isolation is released only while the switch is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Register word address for reads and writes |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| pwr_sw_en | output | 1 | Power-switch enable, 1 = domain supplied |
| pwr_iso_en | output | 1 | Isolation enable, 1 = domain outputs clamped |

## Verification
The assertions assume that bus_wr, bus_addr and bus_wdata are stable, known values at each rising edge. They also assume that a control write issued from idle means a fresh request. The bench holds these assumptions by changing bus inputs only on falling edges and by programming the timing and gating registers only while the sequencer is idle. The bench also makes its one deliberate write during a running sequence to show that such writes are ignored. Its timing vectors cover zero counts, maximum counts and both divide ratios, so every phase-length boundary of R3, R4 and R8 is exercised.

// File: rtl/pwr_switch_seq_pkg.sv
package pwr_switch_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_SECOND = 2'd2
   } seq_phase_e;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } seq_dir_e;

   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_GATE = 1;
   localparam int unsigned REG_TIM_BASE = 2;
   localparam int unsigned NUM_TIM = 2;
   localparam int unsigned TIM_UP = 0;
   localparam int unsigned TIM_DN = 1;
   localparam int unsigned REQ_DN_BIT = 0;
   localparam int unsigned REQ_UP_BIT = 1;
endpackage

// File: rtl/pwr_switch_seq_regs.sv
module pwr_switch_seq_regs
   import pwr_switch_seq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned LO_LSB   = 0,
   parameter int unsigned HI_LSB   = 8,
   parameter int unsigned FAST_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy_up,
   input  logic              busy_dn,
   output logic [DATA_W-1:0] rdata,
   output logic              ctrl_wr,
   output logic [1:0]        ctrl_req,
   output logic              gate_en,
   output logic [CNT_W-1:0]  up_first,
   output logic [CNT_W-1:0]  up_second,
   output logic [CNT_W-1:0]  dn_first,
   output logic [CNT_W-1:0]  dn_second,
   output logic              fast_sel
);
   localparam int unsigned TIM_W = 2 * CNT_W;

   logic [TIM_W-1:0] tim_val [NUM_TIM];
   logic             gate_q;
   logic             unused_wdata;

   assign unused_wdata = ^wdata;
   assign ctrl_wr  = wr && (addr == ADDR_W'(REG_CTRL));
   assign ctrl_req = {wdata[REQ_UP_BIT], wdata[REQ_DN_BIT]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
      end else if (wr && (addr == ADDR_W'(REG_GATE))) begin
         gate_q <= wdata[0];
      end
   end

   for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
      logic [TIM_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr && (addr == ADDR_W'(REG_TIM_BASE + g))) begin
            q <= {wdata[HI_LSB +: CNT_W], wdata[LO_LSB +: CNT_W]};
         end
      end
      assign tim_val[g] = q;
   end

   assign gate_en   = gate_q;
   assign up_first  = tim_val[TIM_UP][CNT_W-1:0];
   assign up_second = tim_val[TIM_UP][TIM_W-1:CNT_W];
   assign dn_first  = tim_val[TIM_DN][CNT_W-1:0];
   assign dn_second = tim_val[TIM_DN][TIM_W-1:CNT_W];
   assign fast_sel  = tim_val[TIM_UP][FAST_BIT - LO_LSB];

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(REG_CTRL): begin
            rdata[REQ_DN_BIT] = busy_dn;
            rdata[REQ_UP_BIT] = busy_up;
         end
         ADDR_W'(REG_GATE): rdata[0] = gate_q;
         ADDR_W'(REG_TIM_BASE + TIM_UP): begin
            rdata[LO_LSB +: CNT_W] = up_first;
            rdata[HI_LSB +: CNT_W] = up_second;
         end
         ADDR_W'(REG_TIM_BASE + TIM_DN): begin
            rdata[LO_LSB +: CNT_W] = dn_first;
            rdata[HI_LSB +: CNT_W] = dn_second;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/pwr_switch_seq_tick.sv
module pwr_switch_seq_tick #(
   parameter int unsigned DIV_SLOW = 2048,
   parameter int unsigned DIV_FAST = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic fast,
   output logic tick
);
   localparam int unsigned PW = $clog2(DIV_SLOW);

   logic [PW-1:0] presc_q;
   logic [PW-1:0] limit;

   if (DIV_FAST == DIV_SLOW) begin : g_single_rate
      logic unused_fast;
      assign unused_fast = fast;
      assign limit = PW'(DIV_SLOW - 1);
   end else begin : g_dual_rate
      assign limit = fast ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
   end

   assign tick = run && (presc_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q <= '0;
      end else if (clr || !run) begin
         presc_q <= '0;
      end else if (presc_q == limit) begin
         presc_q <= '0;
      end else begin
         presc_q <= presc_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwr_switch_seq_fsm.sv
module pwr_switch_seq_fsm
   import pwr_switch_seq_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [1:0]       ctrl_req,
   input  logic             gate_en,
   input  logic [CNT_W-1:0] up_first,
   input  logic [CNT_W-1:0] up_second,
   input  logic [CNT_W-1:0] dn_first,
   input  logic [CNT_W-1:0] dn_second,
   input  logic             fast_sel,
   input  logic             tick,
   output logic             tmr_clr,
   output logic             tmr_run,
   output logic             fast_q,
   output logic             busy_up,
   output logic             busy_dn,
   output logic             sw_en,
   output logic             iso_en
);
   seq_phase_e       phase_q;
   seq_dir_e         dir_q;
   logic [CNT_W-1:0] rem_q;
   logic [CNT_W-1:0] second_q;
   logic             sw_q;
   logic             iso_q;
   logic             idle;
   logic             start_dn;
   logic             start_up;
   logic             phase_done;

   assign idle     = (phase_q == PH_IDLE);
   assign start_dn = idle && ctrl_wr && ctrl_req[0] && gate_en;
   assign start_up = idle && ctrl_wr && !ctrl_req[0] && ctrl_req[1];

   assign phase_done = !idle &&
                       ((rem_q == '0) || ((rem_q == CNT_W'(1)) && tick));

   assign tmr_clr = start_dn || start_up || ((phase_q == PH_FIRST) && phase_done);
   assign tmr_run = !idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         dir_q    <= DIR_DOWN;
         rem_q    <= '0;
         second_q <= '0;
         fast_q   <= 1'b0;
         sw_q     <= 1'b1;
         iso_q    <= 1'b0;
      end else if (start_dn) begin
         phase_q  <= PH_FIRST;
         dir_q    <= DIR_DOWN;
         rem_q    <= dn_first;
         second_q <= dn_second;
         fast_q   <= fast_sel;
         iso_q    <= 1'b1;
      end else if (start_up) begin
         phase_q  <= PH_FIRST;
         dir_q    <= DIR_UP;
         rem_q    <= up_first;
         second_q <= up_second;
         fast_q   <= fast_sel;
         sw_q     <= 1'b1;
      end else if (phase_done) begin
         if (phase_q == PH_FIRST) begin
            phase_q <= PH_SECOND;
            rem_q   <= second_q;
            if (dir_q == DIR_DOWN) begin
               sw_q <= 1'b0;
            end
         end else begin
            phase_q <= PH_IDLE;
            if (dir_q == DIR_UP) begin
               iso_q <= 1'b0;
            end
         end
      end else if (tick && (rem_q != '0)) begin
         rem_q <= rem_q - 1'b1;
      end
   end

   assign busy_dn = !idle && (dir_q == DIR_DOWN);
   assign busy_up = !idle && (dir_q == DIR_UP);
   assign sw_en   = sw_q;
   assign iso_en  = iso_q;
endmodule

// File: rtl/pwr_switch_seq.sv
module pwr_switch_seq #(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned LO_LSB   = 0,
   parameter int unsigned HI_LSB   = 8,
   parameter int unsigned FAST_BIT = 5,
   parameter int unsigned DIV_SLOW = 2048,
   parameter int unsigned DIV_FAST = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwr_sw_en,
   output logic              pwr_iso_en
);
   initial begin : elab_checks
      assert (ADDR_W >= 2) else $error("ADDR_W must reach four registers");
      assert (LO_LSB + CNT_W <= HI_LSB) else $error("timing fields overlap");
      assert (HI_LSB + CNT_W <= DATA_W) else $error("timing field beyond bus width");
      assert (FAST_BIT >= LO_LSB && FAST_BIT < LO_LSB + CNT_W)
         else $error("mode bit must sit in the first count field");
      assert (DIV_SLOW >= 2) else $error("DIV_SLOW must be at least 2");
      assert (DIV_FAST >= 1 && DIV_FAST <= DIV_SLOW) else $error("DIV_FAST out of range");
   end

   logic             ctrl_wr;
   logic [1:0]       ctrl_req;
   logic             gate_en;
   logic [CNT_W-1:0] up_first;
   logic [CNT_W-1:0] up_second;
   logic [CNT_W-1:0] dn_first;
   logic [CNT_W-1:0] dn_second;
   logic             fast_sel;
   logic             fast_q;
   logic             tick;
   logic             tmr_clr;
   logic             tmr_run;
   logic             busy_up;
   logic             busy_dn;

   pwr_switch_seq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .LO_LSB(LO_LSB), .HI_LSB(HI_LSB), .FAST_BIT(FAST_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .busy_up(busy_up), .busy_dn(busy_dn), .rdata(bus_rdata),
      .ctrl_wr(ctrl_wr), .ctrl_req(ctrl_req), .gate_en(gate_en),
      .up_first(up_first), .up_second(up_second),
      .dn_first(dn_first), .dn_second(dn_second), .fast_sel(fast_sel)
   );

   pwr_switch_seq_tick #(
      .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
      .fast(fast_q), .tick(tick)
   );

   pwr_switch_seq_fsm #(
      .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_req(ctrl_req),
      .gate_en(gate_en), .up_first(up_first), .up_second(up_second),
      .dn_first(dn_first), .dn_second(dn_second), .fast_sel(fast_sel),
      .tick(tick), .tmr_clr(tmr_clr), .tmr_run(tmr_run), .fast_q(fast_q),
      .busy_up(busy_up), .busy_dn(busy_dn),
      .sw_en(pwr_sw_en), .iso_en(pwr_iso_en)
   );
endmodule

// File: rtl/pwr_switch_seq_chk.sv
module pwr_switch_seq_chk #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              gate_en,
   input logic              busy_up,
   input logic              busy_dn,
   input logic              pwr_sw_en,
   input logic              pwr_iso_en
);
   logic ctl_wr;
   logic idle;
   logic unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign ctl_wr = bus_wr && (bus_addr == '0);
   assign idle   = !busy_up && !busy_dn;

   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> pwr_sw_en && !pwr_iso_en && idle);

   p_dn_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && bus_wdata[0] && gate_en && idle |=> pwr_iso_en && busy_dn);

   p_dn_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_dn) |-> !pwr_sw_en && pwr_iso_en);

   p_up_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && !bus_wdata[0] && bus_wdata[1] && idle |=> pwr_sw_en && busy_up);

   p_up_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_up) |-> pwr_sw_en && !pwr_iso_en);

   p_gate_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && bus_wdata[0] && !gate_en && idle |=> idle);

   p_dn_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && bus_wdata[0] && bus_wdata[1] && idle |=> !busy_up);

   p_ignore_in_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_dn && ctl_wr |=> !busy_up);

   p_ignore_in_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_up && ctl_wr |=> !busy_dn);

   p_one_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy_up, busy_dn}));

   p_iso_covers_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_sw_en) |-> pwr_iso_en && $past(pwr_iso_en));

   p_iso_release_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_iso_en) |-> pwr_sw_en);
endmodule

bind pwr_switch_seq pwr_switch_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .gate_en(gate_en), .busy_up(busy_up),
   .busy_dn(busy_dn), .pwr_sw_en(pwr_sw_en), .pwr_iso_en(pwr_iso_en)
);

// File: tb/pwr_switch_seq_test.sv
`timescale 1ns/100ps
module pwr_switch_seq_test;
   localparam int DSLOW = 8;
   localparam int DFAST = 2;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_GATE = 2'd1;
   localparam logic [1:0] A_UPT  = 2'd2;
   localparam logic [1:0] A_DNT  = 2'd3;

   // vector fields: {dir(1=up), first[5:0], second[5:0], fast for power-down}
   localparam int NV = 8;
   localparam logic [13:0] VEC [NV] = '{
      {1'b0, 6'd3,  6'd2,  1'b0},
      {1'b1, 6'd2,  6'd1,  1'b0},
      {1'b0, 6'd0,  6'd0,  1'b1},
      {1'b1, 6'd0,  6'd0,  1'b0},
      {1'b0, 6'd5,  6'd0,  1'b1},
      {1'b1, 6'd33, 6'd4,  1'b0},
      {1'b0, 6'd63, 6'd63, 1'b0},
      {1'b1, 6'd1,  6'd63, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pwr_sw_en;
   logic        pwr_iso_en;

   int checks = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   pwr_switch_seq #(.DIV_SLOW(DSLOW), .DIV_FAST(DFAST)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwr_sw_en(pwr_sw_en), .pwr_iso_en(pwr_iso_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   function automatic int plen(input int cnt, input int div);
      return (cnt * div == 0) ? 1 : cnt * div;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual run still going, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 sw_en", {31'd0, pwr_sw_en}, 32'd1);
      chk("R1 iso_en", {31'd0, pwr_iso_en}, 32'd0);
      rd(A_CTRL, r); chk("R1 ctrl", r, 32'd0);
      rd(A_GATE, r); chk("R1 gate", r, 32'd0);
      rd(A_UPT, r);  chk("R1 up timing", r, 32'd0);
      rd(A_DNT, r);  chk("R1 down timing", r, 32'd0);

      // R2 register map and field masks
      wr(A_UPT, 32'hFFFF_FFFF);
      rd(A_UPT, r); chk("R2 up timing mask", r, 32'h0000_3F3F);
      wr(A_DNT, 32'h0000_2A15);
      rd(A_DNT, r); chk("R2 down timing", r, 32'h0000_2A15);
      wr(A_GATE, 32'hFFFF_FFFF);
      rd(A_GATE, r); chk("R2 gate mask", r, 32'd1);
      rd(A_CTRL, r); chk("R2 ctrl idle", r, 32'd0);

      // R5 power-down refused with gating disabled
      wr(A_GATE, 32'd0);
      wr(A_CTRL, 32'd1);
      repeat (20) @(negedge clk);
      rd(A_CTRL, r); chk("R5 ctrl", r, 32'd0);
      chk("R5 sw_en", {31'd0, pwr_sw_en}, 32'd1);
      chk("R5 iso_en", {31'd0, pwr_iso_en}, 32'd0);
      wr(A_GATE, 32'd1);

      // vector walk: R3 / R4 / R8 / R9
      for (int i = 0; i < NV; i++) begin
         logic up;
         logic [5:0] fa, sb;
         logic fast;
         int d, t1, t2, n;
         up = VEC[i][13];
         fa = VEC[i][12:7];
         sb = VEC[i][6:1];
         fast = up ? fa[5] : VEC[i][0];
         d = fast ? DFAST : DSLOW;
         t1 = plen(int'(fa), d);
         t2 = plen(int'(sb), d);
         if (up) begin
            wr(A_UPT, {18'd0, 2'b00, sb, 2'b00, fa});
            wr(A_CTRL, 32'd2);
            chk($sformatf("R4 v%0d sw_en on start", i), {31'd0, pwr_sw_en}, 32'd1);
            rd(A_CTRL, r); chk($sformatf("R9 v%0d up request set", i), r, 32'd2);
            n = 0;
            while (pwr_iso_en && n < 5000) begin @(negedge clk); n++; end
            chk($sformatf("R8 R4 v%0d iso release cycle", i), n, t1 + t2);
            rd(A_CTRL, r); chk($sformatf("R9 v%0d up request cleared", i), r, 32'd0);
            chk($sformatf("R4 v%0d sw_en end", i), {31'd0, pwr_sw_en}, 32'd1);
         end else begin
            wr(A_UPT, {26'd0, fast, 5'd0});
            wr(A_DNT, {18'd0, 2'b00, sb, 2'b00, fa});
            wr(A_CTRL, 32'd1);
            chk($sformatf("R3 v%0d iso_en on start", i), {31'd0, pwr_iso_en}, 32'd1);
            rd(A_CTRL, r); chk($sformatf("R9 v%0d down request set", i), r, 32'd1);
            n = 0;
            while (pwr_sw_en && n < 5000) begin @(negedge clk); n++; end
            chk($sformatf("R8 R3 v%0d switch open cycle", i), n, t1);
            rd(A_CTRL, r);
            while (r[0] && n < 5000) begin @(negedge clk); n++; rd(A_CTRL, r); end
            chk($sformatf("R3 v%0d done cycle", i), n, t1 + t2);
            chk($sformatf("R3 v%0d iso held", i), {31'd0, pwr_iso_en}, 32'd1);
         end
      end

      // R6 both bits: power-down only
      wr(A_DNT, 32'h0000_0101);
      wr(A_CTRL, 32'd3);
      rd(A_CTRL, r); chk("R6 only down request", r, 32'd1);
      chk("R6 iso_en", {31'd0, pwr_iso_en}, 32'd1);
      repeat (40) @(negedge clk);
      chk("R6 domain off", {31'd0, pwr_sw_en}, 32'd0);
      wr(A_GATE, 32'd0);
      wr(A_CTRL, 32'd3);
      repeat (20) @(negedge clk);
      rd(A_CTRL, r); chk("R6 gated both bits ctrl", r, 32'd0);
      chk("R6 gated both bits sw_en", {31'd0, pwr_sw_en}, 32'd0);
      chk("R6 gated both bits iso_en", {31'd0, pwr_iso_en}, 32'd1);

      // R7 writes during a sequence ignored
      wr(A_GATE, 32'd1);
      wr(A_UPT, 32'h0000_0404);
      wr(A_CTRL, 32'd2);
      wr(A_CTRL, 32'd1);
      rd(A_CTRL, r); chk("R7 request unchanged", r, 32'd2);
      begin
         int n = 0;
         rd(A_CTRL, r);
         while (r != 0 && n < 5000) begin @(negedge clk); n++; rd(A_CTRL, r); end
      end
      repeat (30) @(negedge clk);
      rd(A_CTRL, r); chk("R7 no later sequence", r, 32'd0);
      chk("R7 sw_en", {31'd0, pwr_sw_en}, 32'd1);
      chk("R7 iso_en", {31'd0, pwr_iso_en}, 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule